// File: doc/BRIEF.md
# Infrared Link Frame Deframer

This block sits behind the byte-level infrared transceiver and turns its stream of received octets back into frame payload. It waits for the opening flag byte, drops the byte-stuffing that keeps flag values out of the body, and runs a 16-bit CCITT check over every recovered body byte. The two check bytes at the tail are included in that check. When the closing flag arrives, the block pulses a frame-end strobe with a good/bad verdict. The verdict is taken by comparing the check register against a fixed residue, so the block never needs to know the frame length.

Recovered bytes pass through a short delay line two entries deep. A body byte is released upward only when two newer bytes have arrived behind it, so the two check bytes stay in the delay line when the frame closes and are never delivered. A second opening flag in the middle of a frame discards the partial frame and starts over. Any frame too short to hold a check field is rejected.

Top module: `irrx_deframer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `frame_end` and `frame_good` are 0.
- R2: Before an opening flag (0xC0) is seen, every input byte is ignored. This includes 0xC1 and 0x7D. Such bytes produce no payload and no frame-end pulse, and they do not disturb a frame that follows.
- R3: The check is CRC-16 with the reflected polynomial 0x8408. It is seeded with 0xFFFF at the opening flag and processed least significant bit first, one byte at a time. It covers every unescaped body byte, the check bytes included. A frame is reported good only when the register equals 0xF0B8 at the closing flag (0xC1). Any single-bit error in the body or the check bytes yields bad.
- R4: Delivered payload is every unescaped body byte except the final two, in arrival order. A byte is delivered with `out_valid` high in the cycle after the second body byte following it is accepted.
- R5: Byte 0x7D is not data. The body byte after it is XORed with 0x20 before it enters the check and the payload.
- R6: An opening flag inside a frame, including one right after 0x7D, restarts reception. Undelivered bytes and the check state of the old frame are discarded.
- R7: A frame with fewer than two unescaped bytes between its flags is reported bad.
- R8: `frame_end` is a one-cycle pulse in the cycle after the closing flag is accepted. `frame_good` is high only together with `frame_end`.
- R9: A closing flag that arrives right after 0x7D ends the frame as bad.
- R10: Cycles with `in_valid` low have no effect on the frame or its outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received octet is present on `in_byte` |
| in_byte | input | 8 | Received octet from the transceiver |
| out_valid | output | 1 | `out_byte` carries a payload byte |
| out_byte | output | 8 | Payload byte |
| frame_end | output | 1 | One-cycle pulse after the closing flag |
| frame_good | output | 1 | Check residue matched, qualified by `frame_end` |

## Verification
The bench goes after the frame edges. It sends frames whose payloads run from empty to eight bytes, so that a delay line of the wrong depth would deliver the check bytes or swallow real payload. It covers the two-byte minimum, where a design that skips the length guard would accept empty or one-byte frames. It flips each of the 40 bits of a short frame in turn; a wrong seed, polynomial or bit order would let some of those flips through or reject clean frames. It also sends stuffed flag values, an escape followed by either flag, restarts in mid-frame and junk before the first flag. A design that leaked state from an aborted or pre-flag stream would then report a good frame as bad or emit stray bytes.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  localparam logic [7:0]  FLAG_OPEN   = 8'hC0;
  localparam logic [7:0]  FLAG_CLOSE  = 8'hC1;
  localparam logic [7:0]  ESC_MARK    = 8'h7D;
  localparam logic [7:0]  ESC_FLIP    = 8'h20;
  localparam logic [15:0] CRC_SEED    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY    = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_BODY = 2'd1,
    ST_ESC  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/irrx_crc_acc.sv
module irrx_crc_acc #(
  parameter int CW = 16,
  parameter int DW = 8,
  parameter logic [CW-1:0] POLY = 16'h8408,
  parameter logic [CW-1:0] SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] crc
);
  localparam int PADW = CW - DW;

  logic [CW-1:0] crc_nxt;

  // Reflected bytewise update: fold the byte into the low end, then shift right DW times.
  always_comb begin
    logic [CW-1:0] t;
    t = crc ^ {{PADW{1'b0}}, din};
    for (int i = 0; i < DW; i++) begin
      t = t[0] ? ((t >> 1) ^ POLY) : (t >> 1);
    end
    crc_nxt = t;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= SEED;
    else if (en)    crc <= crc_nxt;
  end
endmodule

// File: rtl/irrx_trail_fifo.sv
module irrx_trail_fifo #(
  parameter int DW    = 8,
  parameter int TRAIL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          full
);
  localparam int CNTW = $clog2(TRAIL + 1);

  logic [DW-1:0]   stage [TRAIL];
  logic [CNTW-1:0] cnt;

  assign full = (cnt == CNTW'(TRAIL));

  // Data stages carry no reset so they map to plain shift registers.
  always_ff @(posedge clk) begin
    if (push) stage[0] <= din;
  end

  for (genvar g = 1; g < TRAIL; g++) begin : g_shift
    always_ff @(posedge clk) begin
      if (push) stage[g] <= stage[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (push) begin
        if (full) begin
          out_valid <= 1'b1;
          out_data  <= stage[TRAIL-1];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irrx_deframer.sv
module irrx_deframer
  import irrx_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter int TRAIL = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       frame_end,
  output logic       frame_good
);
  localparam int DW = 8;

  rx_state_t      state, state_nxt;
  logic           is_open, is_close, is_esc, push;
  logic [DW-1:0]  data;
  logic [CRC_W-1:0] crc;
  logic           fifo_full;

  always_comb begin
    is_open  = in_valid && (in_byte == FLAG_OPEN);
    is_close = in_valid && (in_byte == FLAG_CLOSE) && (state != ST_HUNT);
    is_esc   = in_valid && (in_byte == ESC_MARK) && (state == ST_BODY);
    push     = in_valid && !is_open && (in_byte != FLAG_CLOSE) &&
               (((state == ST_BODY) && (in_byte != ESC_MARK)) || (state == ST_ESC));
    data     = (state == ST_ESC) ? (in_byte ^ ESC_FLIP) : in_byte;

    state_nxt = state;
    if (is_open)                      state_nxt = ST_BODY;
    else if (is_close)                state_nxt = ST_HUNT;
    else if (is_esc)                  state_nxt = ST_ESC;
    else if (push && state == ST_ESC) state_nxt = ST_BODY;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_HUNT;
    else     state <= state_nxt;
  end

  irrx_crc_acc #(
    .CW(CRC_W), .DW(DW), .POLY(CRC_W'(CRC_POLY)), .SEED(CRC_W'(CRC_SEED))
  ) crc_i (
    .clk(clk), .rst(rst), .clr(is_open), .en(push), .din(data), .crc(crc)
  );

  irrx_trail_fifo #(.DW(DW), .TRAIL(TRAIL)) fifo_i (
    .clk(clk), .rst(rst), .clr(is_open), .push(push), .din(data),
    .out_valid(out_valid), .out_data(out_byte), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_end  <= 1'b0;
      frame_good <= 1'b0;
    end else begin
      frame_end  <= is_close;
      frame_good <= is_close && (state == ST_BODY) && fifo_full &&
                    (crc == CRC_W'(CRC_RESIDUE));
    end
  end
endmodule

// File: rtl/irrx_deframer_chk.sv
module irrx_deframer_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic frame_end,
  input logic frame_good
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !frame_end && !frame_good));

  a_r8_good_needs_end: assert property (@(posedge clk) disable iff (rst)
    frame_good |-> frame_end);

  a_r8_end_single_cycle: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  a_r4_payload_not_at_end: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !frame_end);

  a_r10_payload_needs_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  a_r10_end_needs_input: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> $past(in_valid));
endmodule

bind irrx_deframer irrx_deframer_chk chk_i (.*);

// File: tb/irrx_deframer_tb_top.sv
`timescale 1ns/1ps
module irrx_deframer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_valid, frame_end, frame_good;
  logic [7:0] out_byte;

  int checks = 0;
  int fails = 0;
  int ends = 0;
  int stray_good = 0;
  int seq = 0;
  logic last_good = 1'b0;
  logic [7:0] got[$];

  always #2 clk = ~clk;

  irrx_deframer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte),
    .frame_end(frame_end), .frame_good(frame_good)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) got.push_back(out_byte);
      if (frame_end) begin ends++; last_good = frame_good; end
      if (frame_good && !frame_end) stray_good++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic idle();
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    seq++;
    if (gap > 0 && (seq % gap) == 0) idle();
  endtask

  task automatic send_body(input logic [7:0] b, input int gap);
    if (b == 8'hC0 || b == 8'hC1 || b == 8'h7D) begin
      send(8'h7D, gap); send(b ^ 8'h20, gap);
    end else send(b, gap);
  endtask

  // Sends preamble, open flag, escaped body with check bytes, close flag, then checks.
  task automatic run_frame(input logic [7:0] pl[$], input int flip, input int pre,
                           input int gap, input string tag);
    logic [7:0] st[$];
    logic [15:0] c = 16'hFFFF;
    int e0;
    st = pl;
    foreach (pl[i]) c = crc_upd(c, pl[i]);
    c = ~c;
    st.push_back(c[7:0]);
    st.push_back(c[15:8]);
    if (flip >= 0) st[flip/8] = st[flip/8] ^ (8'h01 << (flip % 8));
    got.delete();
    e0 = ends;
    repeat (pre) send(8'hFF, gap);
    send(8'hC0, gap);
    foreach (st[i]) send_body(st[i], gap);
    send(8'hC1, gap);
    repeat (3) idle();
    check(ends == e0 + 1, {"R8 frame_end count ", tag}, ends - e0, 1);
    check(last_good == (flip < 0), {"R3 verdict ", tag}, last_good, flip < 0);
    check(got.size() == st.size() - 2, {"R4 payload length ", tag}, got.size(), st.size() - 2);
    for (int i = 0; i < st.size() - 2 && i < got.size(); i++)
      check(got[i] == st[i], {"R4/R5 payload byte ", tag}, got[i], st[i]);
  endtask

  function automatic void mk_payload(output logic [7:0] q[$], input int len);
    q.delete();
    for (int j = 0; j < len; j++) q.push_back(8'((j * 37 + len * 11 + 8'hBD) & 8'hFF));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] pl[$];
    int e0;
    repeat (3) @(negedge clk);
    check(!out_valid && !frame_end && !frame_good, "R1 outputs in reset",
          {out_valid, frame_end, frame_good}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !frame_end && !frame_good, "R1 outputs after reset",
          {out_valid, frame_end, frame_good}, 0);

    // R2: junk before the first flag.
    got.delete(); e0 = ends;
    send(8'hC1, 0); send(8'h7D, 0); send(8'h55, 0); send(8'hC1, 0);
    repeat (2) idle();
    check(ends == e0 && got.size() == 0, "R2 pre-flag bytes ignored", ends - e0 + got.size(), 0);
    mk_payload(pl, 3);
    run_frame(pl, -1, 0, 0, "R2 after junk");

    // R4 latency.
    got.delete();
    send(8'hC0, 0); send(8'h11, 0); send(8'h22, 0); send(8'h33, 0);
    check(!out_valid, "R4 no output before third byte", out_valid, 0);
    idle();
    check(out_valid && out_byte == 8'h11, "R4 first byte latency", {out_valid, out_byte}, 9'h111);
    send(8'hC1, 0); repeat (2) idle();

    // R3/R4/R7 length sweep, with and without gaps (R10), with preamble.
    for (int len = 0; len <= 8; len++) begin
      mk_payload(pl, len);
      run_frame(pl, -1, 2, 0, "R3 len sweep");
      run_frame(pl, -1, 1, 3, "R10 gapped sweep");
    end

    // R5 stuffed values.
    pl = '{8'hC0, 8'h7D, 8'hC1, 8'h20, 8'h5D, 8'hE0};
    run_frame(pl, -1, 0, 0, "R5 stuffed");

    // R3 single-bit error sweep over a 3-byte payload (40 bits).
    mk_payload(pl, 3);
    for (int f = 0; f < 40; f++) run_frame(pl, f, 0, 0, "R3 bit flip");

    // R7 short frames.
    e0 = ends;
    send(8'hC0, 0); send(8'hC1, 0); repeat (2) idle();
    check(ends == e0 + 1 && !last_good, "R7 empty frame bad", last_good, 0);
    send(8'hC0, 0); send(8'h0F, 0); send(8'hC1, 0); repeat (2) idle();
    check(ends == e0 + 2 && !last_good, "R7 one-byte frame bad", last_good, 0);
    send(8'hC0, 0); send(8'h7D, 0); send(8'hE0, 0); send(8'hC1, 0); repeat (2) idle();
    check(ends == e0 + 3 && !last_good, "R7 one escaped byte bad", last_good, 0);

    // R6 restart in mid frame.
    got.delete(); e0 = ends;
    send(8'hC0, 0); send(8'hAA, 0); send(8'hBB, 0); idle();
    check(got.size() == 0 && ends == e0, "R6 held bytes before restart", got.size(), 0);
    mk_payload(pl, 4);
    run_frame(pl, -1, 0, 0, "R6 restart");
    send(8'hC0, 0); send(8'h11, 0); send(8'h7D, 0);
    run_frame(pl, -1, 0, 0, "R6 restart after escape");

    // R9 escape then close.
    got.delete(); e0 = ends;
    send(8'hC0, 0); send(8'h31, 0); send(8'h32, 0); send(8'h33, 0);
    send(8'h7D, 0); send(8'hC1, 0); repeat (2) idle();
    check(ends == e0 + 1 && !last_good, "R9 escape then close bad", last_good, 0);
    check(got.size() == 1 && got[0] == 8'h31, "R9 payload before abort", got.size(), 1);
    mk_payload(pl, 2);
    run_frame(pl, -1, 0, 0, "R9 next frame");

    check(stray_good == 0, "R8 frame_good without frame_end", stray_good, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule